// File: doc/BRIEF.md
# E3 Remote Alarm Bit Monitor

This block watches the received E3 stream one frame at a time. At each frame boundary an upstream framer supplies a strobe, the extracted remote-alarm "A" bit, the BIP-4 value carried in the frame and the BIP-4 value it computed locally. The block works in one of two modes, chosen by a configuration bit.

With parity checking off, the A bit is debounced into a remote (far-end receive failure) defect level. The defect is declared after a run of frames with A at 1 and cleared after a run of frames with A at 0. The run length is 3 frames or 5 frames, chosen by a second configuration bit. With parity checking on, the defect is held low and the run-length select has no effect. Each frame with A at 1 then produces a far-end block error pulse, and each frame whose received and computed BIP-4 values differ produces a local parity error pulse.

Top module: `e3_remote_alarm_mon`

## Requirements
- R1: While `rstN` is low, `remoteDefect`, `febePulse` and `bipErrPulse` are 0 and the run counter is cleared, so a new run after reset starts from zero frames.
- R2: With `cfgLongRun`=0 and `cfgParityEn`=0, `remoteDefect` rises after the clock edge that samples the 3rd consecutive strobed frame with `aBit`=1, and falls after the edge that samples the 3rd consecutive strobed frame with `aBit`=0.
- R3: With `cfgLongRun`=1 and `cfgParityEn`=0, both declaration and clearance need 5 consecutive strobed frames instead of 3.
- R4: A single strobed frame whose `aBit` equals the current defect state restarts the run count from zero.
- R5: While `cfgParityEn`=1, `remoteDefect` is 0 in the same cycle, `cfgLongRun` has no effect, and the run counter is reset, so a run started before parity checking was enabled is not continued after it is disabled.
- R6: With `cfgParityEn`=1, a strobed frame with `aBit`=1 gives `febePulse`=1 for exactly the one cycle after the sampling edge.
- R7: With `cfgParityEn`=1, a strobed frame with `bipRx` different from `bipCalc` gives `bipErrPulse`=1 for exactly the one cycle after the sampling edge. Equal values give no pulse.
- R8: Inputs are ignored in cycles where `frameStb`=0. `febePulse` and `bipErrPulse` stay 0 while `cfgParityEn`=0.
- R9: A change to `cfgLongRun` during a run keeps the current count, and the next strobed frame compares count+1 against the new threshold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| frameStb | input | 1 | One-cycle strobe that marks a frame boundary; the other inputs are valid with it |
| aBit | input | 1 | Remote-alarm bit extracted from the frame |
| bipRx | input | 4 | BIP-4 value carried in the frame |
| bipCalc | input | 4 | BIP-4 value computed locally over the frame |
| cfgLongRun | input | 1 | 0: 3-frame persistence, 1: 5-frame persistence |
| cfgParityEn | input | 1 | 1: parity checking mode (A bit counted as block error) |
| remoteDefect | output | 1 | Remote defect status level |
| febePulse | output | 1 | Far-end block error event pulse |
| bipErrPulse | output | 1 | Local BIP-4 mismatch event pulse |

## Verification
The hardest case to reach is a change of threshold in the middle of a run. The counter must already hold a value that is at least the new, shorter threshold, and it is not visible at the ports. The stimulus builds a run of three clearing frames under the 5-frame setting, then switches to the 3-frame setting just before a fourth clearing frame, which must clear the defect at once. The counter reset caused by parity mode is also hidden. To show it, the stimulus builds a two-frame run, pulses parity mode for one frame, and then checks that three more frames are needed.

// File: rtl/e3_rai_pkg.sv
package e3_rai_pkg;
  // Strobes from the control to the datapath, valid for one clock.
  typedef struct packed {
    logic cntClr;
    logic cntInc;
    logic defToggle;
    logic defClr;
    logic febeHit;
    logic bipSample;
  } raiStrobe_t;
endpackage

// File: rtl/e3_rai_ctrl.sv
module e3_rai_ctrl
  import e3_rai_pkg::*;
#(
  parameter int CNT_W     = 3,
  parameter int SHORT_RUN = 3,
  parameter int LONG_RUN  = 5
) (
  input  logic             frameStb,
  input  logic             aBit,
  input  logic             cfgLongRun,
  input  logic             cfgParityEn,
  input  logic [CNT_W-1:0] runCnt,
  input  logic             defState,
  output raiStrobe_t       strb
);
  localparam logic [CNT_W-1:0] SHORT_LIM = CNT_W'(SHORT_RUN);
  localparam logic [CNT_W-1:0] LONG_LIM  = CNT_W'(LONG_RUN);

  logic [CNT_W-1:0] runLimit;
  logic [CNT_W-1:0] nextCnt;

  assign runLimit = cfgLongRun ? LONG_LIM : SHORT_LIM;
  assign nextCnt  = runCnt + 1'b1;

  always_comb begin
    strb = '0;
    if (cfgParityEn) begin
      strb.cntClr    = 1'b1;
      strb.defClr    = 1'b1;
      strb.febeHit   = frameStb & aBit;
      strb.bipSample = frameStb;
    end else if (frameStb) begin
      if (aBit != defState) begin
        if (nextCnt >= runLimit) begin
          strb.defToggle = 1'b1;
          strb.cntClr    = 1'b1;
        end else begin
          strb.cntInc = 1'b1;
        end
      end else begin
        strb.cntClr = 1'b1;
      end
    end
  end
endmodule

// File: rtl/e3_rai_dp.sv
module e3_rai_dp
  import e3_rai_pkg::*;
#(
  parameter int CNT_W = 3,
  parameter int BIP_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  raiStrobe_t       strb,
  input  logic [BIP_W-1:0] bipRx,
  input  logic [BIP_W-1:0] bipCalc,
  output logic [CNT_W-1:0] runCnt,
  output logic             defState,
  output logic             febeQ,
  output logic             bipErrQ
);
  logic bipMismatch;
  assign bipMismatch = |(bipRx ^ bipCalc);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runCnt <= '0;
    end else if (strb.cntClr) begin
      runCnt <= '0;
    end else if (strb.cntInc) begin
      runCnt <= runCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      defState <= 1'b0;
    end else if (strb.defClr) begin
      defState <= 1'b0;
    end else if (strb.defToggle) begin
      defState <= ~defState;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      febeQ   <= 1'b0;
      bipErrQ <= 1'b0;
    end else begin
      febeQ   <= strb.febeHit;
      bipErrQ <= strb.bipSample & bipMismatch;
    end
  end
endmodule

// File: rtl/e3_remote_alarm_mon.sv
module e3_remote_alarm_mon
  import e3_rai_pkg::*;
#(
  parameter int SHORT_RUN = 3,
  parameter int LONG_RUN  = 5,
  parameter int BIP_W     = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             frameStb,
  input  logic             aBit,
  input  logic [BIP_W-1:0] bipRx,
  input  logic [BIP_W-1:0] bipCalc,
  input  logic             cfgLongRun,
  input  logic             cfgParityEn,
  output logic             remoteDefect,
  output logic             febePulse,
  output logic             bipErrPulse
);
  localparam int MAX_RUN = (LONG_RUN > SHORT_RUN) ? LONG_RUN : SHORT_RUN;
  localparam int CNT_W   = $clog2(MAX_RUN + 1);

  raiStrobe_t       strb;
  logic [CNT_W-1:0] runCnt;
  logic             defState;

  e3_rai_ctrl #(
    .CNT_W(CNT_W), .SHORT_RUN(SHORT_RUN), .LONG_RUN(LONG_RUN)
  ) u_ctrl (
    .frameStb   (frameStb),
    .aBit       (aBit),
    .cfgLongRun (cfgLongRun),
    .cfgParityEn(cfgParityEn),
    .runCnt     (runCnt),
    .defState   (defState),
    .strb       (strb)
  );

  e3_rai_dp #(
    .CNT_W(CNT_W), .BIP_W(BIP_W)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .bipRx   (bipRx),
    .bipCalc (bipCalc),
    .runCnt  (runCnt),
    .defState(defState),
    .febeQ   (febePulse),
    .bipErrQ (bipErrPulse)
  );

  // Parity mode masks the stored defect in the same cycle (R5).
  assign remoteDefect = defState & ~cfgParityEn;
endmodule

// File: rtl/e3_rai_chk.sv
module e3_rai_chk #(
  parameter int BIP_W = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic             frameStb,
  input logic             aBit,
  input logic [BIP_W-1:0] bipRx,
  input logic [BIP_W-1:0] bipCalc,
  input logic             cfgParityEn,
  input logic             remoteDefect,
  input logic             febePulse,
  input logic             bipErrPulse
);
  a_r5_no_defect_in_parity: assert property (@(posedge clk) disable iff (!rstN)
    cfgParityEn |-> !remoteDefect);

  a_r2_rise_needs_alarm: assert property (@(posedge clk) disable iff (!rstN)
    $rose(remoteDefect) |-> $past(frameStb && aBit && !cfgParityEn));

  a_r8_hold_without_strobe: assert property (@(posedge clk) disable iff (!rstN)
    (!frameStb && !cfgParityEn) |=> (cfgParityEn || $stable(remoteDefect)));

  a_r6_febe_follows_alarm: assert property (@(posedge clk) disable iff (!rstN)
    (frameStb && cfgParityEn && aBit) |=> febePulse);

  a_r7_bip_follows_mismatch: assert property (@(posedge clk) disable iff (!rstN)
    (frameStb && cfgParityEn && (bipRx != bipCalc)) |=> bipErrPulse);

  a_r8_no_pulse_without_strobe: assert property (@(posedge clk) disable iff (!rstN)
    !frameStb |=> (!febePulse && !bipErrPulse));

  a_r8_no_pulse_outside_parity: assert property (@(posedge clk) disable iff (!rstN)
    !cfgParityEn |=> (!febePulse && !bipErrPulse));
endmodule

bind e3_remote_alarm_mon e3_rai_chk #(.BIP_W(BIP_W)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .frameStb    (frameStb),
  .aBit        (aBit),
  .bipRx       (bipRx),
  .bipCalc     (bipCalc),
  .cfgParityEn (cfgParityEn),
  .remoteDefect(remoteDefect),
  .febePulse   (febePulse),
  .bipErrPulse (bipErrPulse)
);

// File: tb/test_e3_remote_alarm_mon.sv
module test_e3_remote_alarm_mon;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       frameStb = 1'b0;
  logic       aBit = 1'b0;
  logic [3:0] bipRx = '0;
  logic [3:0] bipCalc = '0;
  logic       cfgLongRun = 1'b0;
  logic       cfgParityEn = 1'b0;
  logic       remoteDefect, febePulse, bipErrPulse;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  e3_remote_alarm_mon i_e3_remote_alarm_mon (
    .clk(clk), .rstN(rstN), .frameStb(frameStb), .aBit(aBit),
    .bipRx(bipRx), .bipCalc(bipCalc), .cfgLongRun(cfgLongRun),
    .cfgParityEn(cfgParityEn), .remoteDefect(remoteDefect),
    .febePulse(febePulse), .bipErrPulse(bipErrPulse)
  );

  // {stb, a, rx[4], calc[4], long, parity, expDef, expFebe, expBip, req[4]}
  localparam int NV = 37;
  localparam logic [18:0] VEC [NV] = '{
    {1'b1,1'b1,4'h1,4'h2,1'b0,1'b0,1'b0,1'b0,1'b0,4'd8}, // 0 mismatch, no parity: no pulse
    {1'b1,1'b1,4'h0,4'h0,1'b0,1'b0,1'b0,1'b0,1'b0,4'd2}, // 1 run 2
    {1'b1,1'b0,4'h0,4'h0,1'b0,1'b0,1'b0,1'b0,1'b0,4'd4}, // 2 break
    {1'b1,1'b1,4'h0,4'h0,1'b0,1'b0,1'b0,1'b0,1'b0,4'd4}, // 3 run 1
    {1'b0,1'b0,4'h0,4'h0,1'b0,1'b0,1'b0,1'b0,1'b0,4'd8}, // 4 no strobe ignored
    {1'b1,1'b1,4'h0,4'h0,1'b0,1'b0,1'b0,1'b0,1'b0,4'd2}, // 5 run 2
    {1'b1,1'b1,4'h0,4'h0,1'b0,1'b0,1'b1,1'b0,1'b0,4'd2}, // 6 declare
    {1'b1,1'b0,4'h0,4'h0,1'b0,1'b0,1'b1,1'b0,1'b0,4'd2}, // 7
    {1'b1,1'b0,4'h0,4'h0,1'b0,1'b0,1'b1,1'b0,1'b0,4'd2}, // 8
    {1'b1,1'b1,4'h0,4'h0,1'b0,1'b0,1'b1,1'b0,1'b0,4'd4}, // 9 break
    {1'b1,1'b0,4'h0,4'h0,1'b0,1'b0,1'b1,1'b0,1'b0,4'd4}, // 10
    {1'b1,1'b0,4'h0,4'h0,1'b0,1'b0,1'b1,1'b0,1'b0,4'd4}, // 11
    {1'b1,1'b0,4'h0,4'h0,1'b0,1'b0,1'b0,1'b0,1'b0,4'd2}, // 12 clear
    {1'b1,1'b1,4'h0,4'h0,1'b1,1'b0,1'b0,1'b0,1'b0,4'd3}, // 13 long
    {1'b1,1'b1,4'h0,4'h0,1'b1,1'b0,1'b0,1'b0,1'b0,4'd3},
    {1'b1,1'b1,4'h0,4'h0,1'b1,1'b0,1'b0,1'b0,1'b0,4'd3},
    {1'b1,1'b1,4'h0,4'h0,1'b1,1'b0,1'b0,1'b0,1'b0,4'd3}, // 16 four frames: still 0
    {1'b1,1'b1,4'h0,4'h0,1'b1,1'b0,1'b1,1'b0,1'b0,4'd3}, // 17 fifth: declare
    {1'b1,1'b0,4'h0,4'h0,1'b1,1'b0,1'b1,1'b0,1'b0,4'd3},
    {1'b1,1'b0,4'h0,4'h0,1'b1,1'b0,1'b1,1'b0,1'b0,4'd3},
    {1'b1,1'b0,4'h0,4'h0,1'b1,1'b0,1'b1,1'b0,1'b0,4'd3}, // 20 count 3
    {1'b1,1'b0,4'h0,4'h0,1'b0,1'b0,1'b0,1'b0,1'b0,4'd9}, // 21 switch to short: clear
    {1'b1,1'b1,4'h5,4'h5,1'b0,1'b1,1'b0,1'b1,1'b0,4'd6}, // 22 febe only
    {1'b1,1'b0,4'h3,4'h2,1'b0,1'b1,1'b0,1'b0,1'b1,4'd7}, // 23 bip only
    {1'b1,1'b1,4'hF,4'h0,1'b0,1'b1,1'b0,1'b1,1'b1,4'd7}, // 24 both
    {1'b0,1'b1,4'hF,4'h0,1'b0,1'b1,1'b0,1'b0,1'b0,4'd8}, // 25 no strobe
    {1'b1,1'b1,4'h0,4'h0,1'b1,1'b1,1'b0,1'b1,1'b0,4'd5}, // 26 long ignored
    {1'b1,1'b1,4'h0,4'h0,1'b0,1'b0,1'b0,1'b0,1'b0,4'd5},
    {1'b1,1'b1,4'h0,4'h0,1'b0,1'b0,1'b0,1'b0,1'b0,4'd5},
    {1'b1,1'b1,4'h0,4'h0,1'b0,1'b0,1'b1,1'b0,1'b0,4'd5}, // 29 declared
    {1'b0,1'b0,4'h0,4'h0,1'b0,1'b1,1'b0,1'b0,1'b0,4'd5}, // 30 parity forces low
    {1'b1,1'b1,4'h0,4'h0,1'b0,1'b0,1'b0,1'b0,1'b0,4'd5}, // 31 run 1
    {1'b1,1'b1,4'h0,4'h0,1'b0,1'b0,1'b0,1'b0,1'b0,4'd5}, // 32 run 2
    {1'b0,1'b0,4'h0,4'h0,1'b0,1'b1,1'b0,1'b0,1'b0,4'd5}, // 33 parity clears count
    {1'b1,1'b1,4'h0,4'h0,1'b0,1'b0,1'b0,1'b0,1'b0,4'd5},
    {1'b1,1'b1,4'h0,4'h0,1'b0,1'b0,1'b0,1'b0,1'b0,4'd5},
    {1'b1,1'b1,4'h0,4'h0,1'b0,1'b0,1'b1,1'b0,1'b0,4'd5}  // 36 declared after fresh run
  };

  function automatic string tagOf(input logic [3:0] n);
    case (n)
      4'd1: return "R1";
      4'd2: return "R2";
      4'd3: return "R3";
      4'd4: return "R4";
      4'd5: return "R5";
      4'd6: return "R6";
      4'd7: return "R7";
      4'd8: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic checkOut(input string tag, input logic d, input logic f, input logic b);
    checks++;
    if ({remoteDefect, febePulse, bipErrPulse} !== {d, f, b}) begin
      failures++;
      $display("FAIL %s def/febe/bip actual=%b%b%b expected=%b%b%b",
               tag, remoteDefect, febePulse, bipErrPulse, d, f, b);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    checkOut("R1", 1'b0, 1'b0, 1'b0);
    rstN = 1'b1;
    for (int i = 0; i < NV; i++) begin
      {frameStb, aBit, bipRx, bipCalc, cfgLongRun, cfgParityEn} = VEC[i][18:7];
      @(negedge clk);
      checkOut(tagOf(VEC[i][3:0]), VEC[i][6], VEC[i][5], VEC[i][4]);
    end
    // Pulse lasts a single cycle (R6, R7)
    {frameStb, aBit, bipRx, bipCalc, cfgLongRun, cfgParityEn} = {1'b1,1'b1,4'h1,4'h0,1'b0,1'b1};
    @(negedge clk);
    checkOut("R6", 1'b0, 1'b1, 1'b1);
    frameStb = 1'b0;
    @(negedge clk);
    checkOut("R7", 1'b0, 1'b0, 1'b0);
    // Build a defect, then reset asynchronously (R1)
    {frameStb, aBit, cfgParityEn} = 3'b110;
    repeat (3) @(negedge clk);
    checkOut("R2", 1'b1, 1'b0, 1'b0);
    aBit = 1'b0;
    @(negedge clk);
    rstN = 1'b0;
    #1;
    checkOut("R1", 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    rstN = 1'b1;
    aBit = 1'b1;
    repeat (2) @(negedge clk);
    checkOut("R1", 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    checkOut("R1", 1'b1, 1'b0, 1'b0);
    frameStb = 1'b0;
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule